// File: doc/BRIEF.md
# Two-Lane Unfolded Lag-Nine Recursive Filter

This block evaluates the first-order recursion y(n) = a·y(n-9) + x(n) on a stream of 16-bit signed samples. The recursion is unfolded by two. A front end pairs each even-position sample with the odd-position sample that follows it. A core then computes both outputs of the pair in the same block step. A back end replays the two results as a serial stream, even result first. The effective block rate is half the sample rate, so the arithmetic has two sample periods in which to settle.

The nine-sample feedback lag does not split evenly over two lanes. The even lane therefore reads the odd-lane result from five blocks earlier, and the odd lane reads the even-lane result from four blocks earlier. Each result is stored in exactly one delay line. Between them, those lines reach the two future blocks that need it. The coefficient `a` is a Q1.15 value held on a port. The scaled product is rounded toward minus infinity, and the sum clips to the 16-bit range.

Samples may arrive with idle cycles between them. Only accepted samples advance the even/odd pairing and the feedback history.

Top module: `unfold2_iir`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_valid` is low, all feedback history is zero and the next accepted sample is treated as even. As a result, the first nine outputs after reset equal their inputs.
- R2: For every accepted sample, y(n) = sat(floor(a·y(n-9) / 2^15) + x(n)). Here `a` is the signed value on `coef` and the result is a 16-bit two's complement number.
- R3: The pairing counts accepted samples only (`in_valid` high at a clock edge). Idle cycles, including idle cycles between the even and odd sample of a pair, change neither the pairing nor the results.
- R4: The even output of block k uses the odd result of block k-5, and the odd output of block k uses the even result of block k-4. This gives a lag of nine samples across both lanes.
- R5: The scaled product is floored, not rounded toward zero. For example, a = 1 times y = -1 contributes -1.
- R6: A sum above 32767 gives 32767, and a sum below -32768 gives -32768.
- R7: If the odd sample of a block is presented in clock cycle c, then `out_valid` is high with y(2k) in cycle c+2 and with y(2k+1) in cycle c+3.
- R8: `out_valid` is high only in the cycles named in R7. An unpaired even sample produces no output until its odd partner arrives.
- R9: The full-scale coefficient a = -32768 (−1.0) is handled without wrap. For example, −1.0 times −32768 contributes +32768 before saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef | input | 16 | Feedback coefficient a, signed Q1.15 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Serial input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Serial output sample, signed |

## Verification
The bench builds the filter with its default lag of nine, which gives lane depths of five and four. Both the crossed routing and the unequal depths are therefore exercised. A scoreboard holds expected values from a sample-by-sample model of the recursion, together with the cycle each value is due.

The stimulus covers several cases: an impulse decaying over many lag periods, irregular gaps (including gaps inside a pair), floor rounding of tiny products, saturation in both directions, the −1.0 coefficient, an unpaired even sample, and a reset in the middle of a stream.

// File: rtl/unfold2_pkg.sv
package unfold2_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_FRAC = 15;
    localparam int PROD_W    = 2 * SAMPLE_W;
    localparam int SCALED_W  = SAMPLE_W + 1;
    localparam int SUM_W     = SAMPLE_W + 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [SAMPLE_W-1:0] coef_t;

    typedef struct packed {
        sample_t ev;
        sample_t od;
    } pair_t;

    localparam sample_t SAT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam sample_t SAT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // floor(a*y / 2^FRAC) + x, clipped to the sample range
    function automatic sample_t fb_mac(sample_t x, sample_t y_old, coef_t a);
        logic signed [PROD_W-1:0] prod;
        logic [SCALED_W-1:0]      scaled;
        logic [SUM_W-1:0]         sum;
        prod   = PROD_W'(a) * PROD_W'(y_old);
        scaled = prod[SAMPLE_W+COEF_FRAC-1+1:COEF_FRAC];
        sum    = {scaled[SCALED_W-1], scaled} + {{2{x[SAMPLE_W-1]}}, x};
        if ((&sum[SUM_W-1:SAMPLE_W-1]) || ~(|sum[SUM_W-1:SAMPLE_W-1]))
            return sample_t'(sum[SAMPLE_W-1:0]);
        else if (sum[SUM_W-1])
            return SAT_MIN;
        else
            return SAT_MAX;
    endfunction

endpackage

// File: rtl/unfold2_s2p.sv
module unfold2_s2p
    import unfold2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_data,
    output logic    blk_valid,
    output pair_t   blk
);
    logic    phase;
    sample_t even_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= 1'b0;
            even_q <= '0;
        end else if (in_valid) begin
            phase <= ~phase;
            if (!phase) even_q <= in_data;
        end
    end

    assign blk_valid = in_valid & phase;
    assign blk.ev    = even_q;
    assign blk.od    = in_data;

    // R3
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (phase != $past(phase)));

    // R3
    phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase) && $stable(even_q));
endmodule

// File: rtl/unfold2_fb_delay.sv
module unfold2_fb_delay
    import unfold2_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t d,
    output sample_t q
);
    sample_t taps [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)     taps[0] <= '0;
                else if (en) taps[0] <= d;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)     taps[i] <= '0;
                else if (en) taps[i] <= taps[i-1];
            end
        end
    end

    assign q = taps[DEPTH-1];

    // R3
    taps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));
endmodule

// File: rtl/unfold2_core.sv
module unfold2_core
    import unfold2_pkg::*;
#(
    parameter int LAG = 9
) (
    input  logic    clk,
    input  logic    rst,
    input  coef_t   coef,
    input  logic    blk_valid,
    input  pair_t   blk,
    output logic    res_valid,
    output pair_t   res
);
    // odd lag: even lane reads odd history, odd lane reads even history
    localparam int ODD_DEPTH  = (LAG + 1) / 2;
    localparam int EVEN_DEPTH = (LAG - 1) / 2;

    sample_t odd_old, even_old;
    pair_t   nxt;

    assign nxt.ev = fb_mac(blk.ev, odd_old, coef);
    assign nxt.od = fb_mac(blk.od, even_old, coef);

    unfold2_fb_delay #(.DEPTH(ODD_DEPTH)) u_odd_hist (
        .clk(clk), .rst(rst), .en(blk_valid), .d(nxt.od), .q(odd_old)
    );

    unfold2_fb_delay #(.DEPTH(EVEN_DEPTH)) u_even_hist (
        .clk(clk), .rst(rst), .en(blk_valid), .d(nxt.ev), .q(even_old)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= blk_valid;
            if (blk_valid) res <= nxt;
        end
    end

    // R7
    res_src_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(blk_valid));
endmodule

// File: rtl/unfold2_p2s.sv
module unfold2_p2s
    import unfold2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    res_valid,
    input  pair_t   res,
    output logic    out_valid,
    output sample_t out_data
);
    logic    pend;
    sample_t odd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            odd_hold  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (res_valid) begin
            out_data  <= res.ev;
            odd_hold  <= res.od;
            out_valid <= 1'b1;
            pend      <= 1'b1;
        end else if (pend) begin
            out_data  <= odd_hold;
            out_valid <= 1'b1;
            pend      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R7
    pair_emit_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> out_valid ##1 out_valid);

    // R8
    out_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(res_valid) || $past(res_valid, 2)));
endmodule

// File: rtl/unfold2_iir.sv
module unfold2_iir
    import unfold2_pkg::*;
#(
    parameter int LAG = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] coef,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);
    logic    blk_valid, res_valid;
    pair_t   blk, res;
    sample_t out_s;

    unfold2_s2p u_s2p (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(sample_t'(in_data)),
        .blk_valid(blk_valid), .blk(blk)
    );

    unfold2_core #(.LAG(LAG)) u_core (
        .clk(clk), .rst(rst), .coef(coef_t'(coef)), .blk_valid(blk_valid),
        .blk(blk), .res_valid(res_valid), .res(res)
    );

    unfold2_p2s u_p2s (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res(res),
        .out_valid(out_valid), .out_data(out_s)
    );

    assign out_data = out_s;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/unfold2_iir_tb.sv
module unfold2_iir_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAG        = 9;

    typedef struct {
        int    val;
        int    due;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] coef = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    hist [0:4095];
    int    n = 0;
    int    a_cur = 0;
    string cur_req = "R2";
    exp_t  sb [$];
    bit    done = 0;
    int    lfsr = 32'h1ace;

    unfold2_iir #(.LAG(LAG)) u_dut (
        .clk(clk), .rst(rst), .coef(coef), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int model(int x, int a, int yold);
        longint p;
        longint s;
        p = longint'(a) * longint'(yold);
        p = p >>> 15;
        s = p + longint'(x);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic check(bit ok, string req, int act, int expv, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic send(int x);
        int yold;
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(x);
        yold = (n >= LAG) ? hist[n-LAG] : 0;
        hist[n] = model(x, a_cur, yold);
        if (n % 2 == 1) begin
            e.val = hist[n-1]; e.due = cyc + 2;
            e.req = (n - 1 < LAG) ? "R1" : cur_req;
            sb.push_back(e);
            e.val = hist[n];   e.due = cyc + 3;
            e.req = (n < LAG) ? "R1" : cur_req;
            sb.push_back(e);
        end
        n++;
    endtask

    task automatic idle(int k);
        repeat (k) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic restart(int a);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        a_cur = a;
        coef = 16'(a);
        n = 0;
        sb.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0, "out_valid during reset");
        rst = 1'b0;
    endtask

    function automatic int next_rand();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
        return lfsr;
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R8", int'(out_valid), 0, "unexpected out_valid");
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(int'($signed(out_data)) == e.val, e.req,
                              int'($signed(out_data)), e.val, "output value");
                        check(cyc == e.due, "R7", cyc, e.due, "output cycle");
                    end
                end else if (sb.size() > 0 && sb[0].due <= cyc) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(1'b0, "R7", -1, e.val, "missing output");
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0, "out_valid after reset");
        check(out_data == 16'd0, "R1", int'(out_data), 0, "out_data after reset");

        // R4: impulse with a = 0.5 decays across alternating lanes
        cur_req = "R4";
        restart(16384);
        send(16384);
        for (int i = 0; i < 39; i++) send(0);
        idle(6);

        // R2 / R3: irregular gaps, including inside a pair, negative coefficient
        cur_req = "R3";
        restart(-20000);
        for (int i = 0; i < 60; i++) begin
            send((next_rand() % 60000) - 30000);
            idle(next_rand() % 4);
        end
        idle(6);

        cur_req = "R2";
        restart(25000);
        for (int i = 0; i < 40; i++) send((next_rand() % 20000) - 10000);
        idle(6);

        // R5: floor rounding of a tiny product
        cur_req = "R5";
        restart(1);
        send(-1);
        for (int i = 0; i < 29; i++) send(0);
        idle(6);

        // R6: saturation in both directions
        cur_req = "R6";
        restart(32767);
        for (int i = 0; i < 30; i++) send(30000);
        for (int i = 0; i < 30; i++) send(-30000);
        idle(6);

        // R9: coefficient -1.0 against the most negative sample
        cur_req = "R9";
        restart(-32768);
        send(-32768);
        for (int i = 0; i < 8; i++) send(0);
        send(0);
        send(-32768);
        for (int i = 0; i < 15; i++) send(0);
        idle(6);

        // R8: unpaired even sample stays silent until its partner arrives
        cur_req = "R8";
        restart(8000);
        send(1234);
        idle(1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R8", int'(out_valid), 0, "unpaired even output");
        end
        send(-777);
        for (int i = 0; i < 20; i++) send(i * 100);
        idle(6);

        // R1: reset in the middle of a stream clears history and pairing
        cur_req = "R1";
        restart(30000);
        for (int i = 0; i < 15; i++) send(5000);
        idle(1);
        restart(30000);
        for (int i = 0; i < 24; i++) send(-3000 + i);
        idle(6);

        check(sb.size() == 0, "R7", sb.size(), 0, "scoreboard drained");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule